// File: doc/BRIEF.md
# Multi-Channel ADC Scan Controller

This block sequences an external successive-approximation converter on behalf of software. One control register, written as a whole, holds a channel mask, a burst-rate divider, a burst enable, a three-bit start mode, an edge polarity bit and a converter enable. The block tells the converter which channel to sample with a one-cycle start pulse. The converter answers with a one-cycle completion pulse that carries a 10-bit sample. The block captures the sample together with the number of the channel converted and raises a DONE flag that a read strobe clears.

Conversions begin in one of three ways. A software-start write converts once. A transition on one of six timer event inputs converts once. Burst mode scans the masked channels in ascending order, wraps around, and pauses for a programmable gap between conversions. Rewriting the control register during a conversion abandons it with DONE raised and applies the new settings at once. A chip-wide power-down input overrides the enable bit.

Top module: `adc_scan_ctrl`

## Requirements
- R1: With burst (bit 16) set, the block converts only channels whose mask bit (bits 7:0) is 1. It begins at the lowest set bit and moves upward, wrapping from the highest selected channel back to the lowest. A single middle channel or two adjacent channels are scanned exactly as selected.
- R2: In burst mode the next conv_start is asserted DIV+2 cycles after the cycle in which conv_done is high, where DIV is bits 15:8.
- R3: A write with burst clear stops burst scanning, so no further conv_start follows.
- R4: When one write sets burst and a new mask together, the first conversion uses the lowest bit of the new mask. That channel is converted once before the scan moves on.
- R5: On each accepted completion, result takes conv_data and result_chan takes the channel that was converted. Otherwise both hold.
- R6: done rises on each accepted completion and falls on rd_result. When both happen in the same cycle, the completion wins.
- R7: With burst clear, a write with start field (bits 19:17) = 001 produces exactly one conversion, of the lowest selected channel.
- R8: Start field values 010 to 111 select trig_in[value-2]. With bit 20 = 0 a rising transition starts one conversion of the lowest selected channel; with bit 20 = 1 a falling transition does. The level at write time starts nothing, and neither does activity on unselected inputs.
- R9: A write while a conversion is outstanding sets done in the following cycle and leaves result unchanged. If the new settings call for it, a new conversion starts immediately.
- R10: conv_pwr equals bit 21 AND NOT sys_pd. While it is low no conv_start is issued, and an outstanding conversion is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 22 | Control register write value |
| rd_result | input | 1 | Result read strobe, clears done |
| sys_pd | input | 1 | Chip-wide power-down request |
| trig_in | input | 6 | Timer event inputs for edge start |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter sample, valid with conv_done |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel to convert, valid with conv_start |
| conv_pwr | output | 1 | Converter power enable |
| result | output | 10 | Last captured sample |
| result_chan | output | 3 | Channel number of the last captured sample |
| done | output | 1 | Sample-ready flag |

## Verification
The assertions check on every cycle that each start names a masked channel, that power-down suppresses starts, and that done follows completions, aborting writes and reads. They also check that the result changes only when a completion is accepted. Only the bench scenarios can show the ascending wrap order of a whole scan and the gap between burst starts. The same holds for the single conversion from a software start and for edge starts that ignore the level present at write time. The bench's own converter model supplies the sample values it compares.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int RES_W  = 10;
  localparam int DIV_W  = 8;
  localparam int MODE_W = 3;
  localparam int NTRIG  = 6;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SW  = 3'b001;

  // packs from bit 0 upward: mask, div, burst, mode, fall, pwr
  typedef struct packed {
    logic              pwr;
    logic              fall;
    logic [MODE_W-1:0] mode;
    logic              burst;
    logic [DIV_W-1:0]  div;
    logic [NCH-1:0]    mask;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_GAP} seq_state_e;

  function automatic logic [CH_W-1:0] lowest_sel(input logic [NCH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  function automatic logic [CH_W-1:0] next_sel(input logic [NCH-1:0] m,
                                               input logic [CH_W-1:0] cur);
    logic [CH_W-1:0] r;
    logic found;
    r = cur;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(cur) + k) % NCH;
      if (!found && m[idx]) begin
        r = CH_W'(idx);
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick
  import adc_scan_pkg::*;
(
  input  logic [NCH-1:0]  mask,
  input  logic [CH_W-1:0] cur,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] next_ch,
  output logic            any_sel
);
  assign first_ch = lowest_sel(mask);
  assign next_ch  = next_sel(mask, cur);
  assign any_sel  = |mask;
endmodule

// File: rtl/adc_edge_trig.sv
module adc_edge_trig
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTRIG-1:0]  trig_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              fall,
  output logic              hit
);
  logic [NTRIG-1:0] prev_q;
  logic [NTRIG-1:0] edge_v;
  logic [NTRIG-1:0] pick_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= trig_in;
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    assign edge_v[g] = fall ? (prev_q[g] & ~trig_in[g]) : (~prev_q[g] & trig_in[g]);
    assign pick_v[g] = (int'(mode) == g + 2);
  end

  assign hit = |(edge_v & pick_v);
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [DIV_W-1:0] cnt_q;

  assign expired = run & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_result,
  input  logic              sys_pd,
  input  logic [NTRIG-1:0]  trig_in,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_pwr,
  output logic [RES_W-1:0]  result,
  output logic [CH_W-1:0]   result_chan,
  output logic              done
);
  ctrl_t      ctrl_q, ctrl_n;
  seq_state_e state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic start_d, gap_load;
  logic done_q;
  logic [RES_W-1:0] result_q;
  logic [CH_W-1:0]  rchan_q;
  logic conv_start_q;

  // named internal events
  logic pwr_n, busy_w, accept_w, wr_go, trig_go, trig_hit, gap_expired;
  logic [CH_W-1:0] first_ch, next_ch;
  logic any_sel;
  logic [NCH-1:0] mask_w;

  assign ctrl_n   = wr_en ? ctrl_t'(wr_data) : ctrl_q;
  assign pwr_n    = ctrl_n.pwr & ~sys_pd;
  assign busy_w   = (state_q == S_BUSY);
  assign accept_w = busy_w & conv_done;
  assign wr_go    = wr_en & (ctrl_n.burst | (ctrl_n.mode == MODE_SW));
  assign trig_go  = ~wr_en & ~ctrl_q.burst & (state_q == S_IDLE) & trig_hit;
  assign mask_w   = ctrl_q.mask;

  adc_chan_pick u_pick (
    .mask     (ctrl_n.mask),
    .cur      (chan_q),
    .first_ch (first_ch),
    .next_ch  (next_ch),
    .any_sel  (any_sel)
  );

  adc_edge_trig u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .mode    (ctrl_q.mode),
    .fall    (ctrl_q.fall),
    .hit     (trig_hit)
  );

  adc_gap_timer u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (ctrl_q.div),
    .run      (state_q == S_GAP),
    .expired  (gap_expired)
  );

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    start_d  = 1'b0;
    gap_load = 1'b0;
    if (!pwr_n) begin
      state_d = S_IDLE;
    end else if (wr_en) begin
      if (wr_go && any_sel) begin
        state_d = S_BUSY;
        chan_d  = first_ch;
        start_d = 1'b1;
      end else begin
        state_d = S_IDLE;
      end
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (trig_go && any_sel) begin
            state_d = S_BUSY;
            chan_d  = first_ch;
            start_d = 1'b1;
          end
        end
        S_BUSY: begin
          if (accept_w) begin
            if (ctrl_q.burst) begin
              state_d  = S_GAP;
              chan_d   = next_ch;
              gap_load = 1'b1;
            end else begin
              state_d = S_IDLE;
            end
          end
        end
        S_GAP: begin
          if (gap_expired) begin
            state_d = S_BUSY;
            start_d = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      state_q      <= S_IDLE;
      chan_q       <= '0;
      conv_start_q <= 1'b0;
      done_q       <= 1'b0;
      result_q     <= '0;
      rchan_q      <= '0;
    end else begin
      ctrl_q       <= ctrl_n;
      state_q      <= state_d;
      chan_q       <= chan_d;
      conv_start_q <= start_d;
      if (accept_w || (wr_en && busy_w)) done_q <= 1'b1;
      else if (rd_result)                done_q <= 1'b0;
      if (accept_w) begin
        result_q <= conv_data;
        rchan_q  <= chan_q;
      end
    end
  end

  assign conv_start  = conv_start_q;
  assign conv_chan   = chan_q;
  assign conv_pwr    = ctrl_q.pwr & ~sys_pd;
  assign result      = result_q;
  assign result_chan = rchan_q;
  assign done        = done_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
  import adc_scan_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_result,
  input logic             sys_pd,
  input logic             conv_start,
  input logic [CH_W-1:0]  conv_chan,
  input logic [RES_W-1:0] result,
  input logic             done,
  input logic             busy_w,
  input logic             accept_w,
  input logic [NCH-1:0]   mask_w
);
  p_start_in_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> mask_w[conv_chan]);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(result));

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> done);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_result && !accept_w && !(wr_en && busy_w)) |=> !done);

  p_abort_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy_w) |=> done);

  p_pd_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pd |=> !conv_start);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_result  (rd_result),
  .sys_pd     (sys_pd),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .result     (result),
  .done       (done),
  .busy_w     (busy_w),
  .accept_w   (accept_w),
  .mask_w     (mask_w)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [21:0] wr_data = '0;
  logic        rd_result = 1'b0;
  logic        sys_pd = 1'b0;
  logic [5:0]  trig_in = '0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_pwr;
  logic [9:0]  result;
  logic [2:0]  result_chan;
  logic        done;

  adc_scan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_result(rd_result), .sys_pd(sys_pd), .trig_in(trig_in),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_pwr(conv_pwr), .result(result),
    .result_chan(result_chan), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // start log observed at the ports
  int log_ch[64];
  int log_cy[64];
  int nlog = 0;
  always @(negedge clk) begin
    if (conv_start && nlog < 64) begin
      log_ch[nlog] = int'(conv_chan);
      log_cy[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  // converter model: completion 4 negedges after start is seen
  int mcnt = 0;
  int mseq = 0;
  logic [2:0] mch = '0;
  logic [9:0] last_data = '0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (conv_start) begin
      mcnt = 4;
      mch  = conv_chan;
    end else if (mcnt > 0) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) begin
        last_data = {mch, 7'(mseq)};
        conv_data = last_data;
        mseq = mseq + 1;
        conv_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input int mask, input int div, input bit burst,
                                     input int mode, input bit fall, input bit pwr);
    return {pwr, fall, 3'(mode), burst, 8'(div), 8'(mask)};
  endfunction

  function automatic int exp_ch(input int mask, input int k);
    int lst[8];
    int n;
    n = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) begin lst[n] = i; n++; end
    return lst[k % n];
  endfunction

  function automatic int popc(input int mask);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) n++;
    return n;
  endfunction

  task automatic wait_cy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [21:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1 nlog = 0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_result = 1'b1;
    @(negedge clk);
    rd_result = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 400 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic run_burst(input int mask, input int div, input int n);
    wr(mk(mask, div, 1'b1, 0, 1'b0, 1'b1));
    wait_log(n);
    chk(nlog >= n, "R1 burst start count", nlog, n);
    for (int k = 0; k < n; k++)
      chk(log_ch[k] == exp_ch(mask, k), "R1/R4 scan channel", log_ch[k], exp_ch(mask, k));
    if (n >= 2)
      chk(log_cy[1] - log_cy[0] == 6 + div, "R2 burst interval", log_cy[1] - log_cy[0], 6 + div);
    wr(mk(mask, div, 1'b0, 0, 1'b0, 1'b1));
    wait_cy(40);
    chk(nlog == 0, "R3 burst stopped", nlog, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    logic [9:0] res_before;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R6 reset done", done, 0);
    chk(conv_start == 1'b0, "R10 reset start", conv_start, 0);
    chk(conv_pwr == 1'b0, "R10 reset pwr", conv_pwr, 0);
    chk(result == '0, "R5 reset result", result, 0);

    // R10: converter disabled
    wr(mk(8'hFF, 0, 1'b1, 0, 1'b0, 1'b0));
    wait_cy(40);
    chk(nlog == 0, "R10 no start while disabled", nlog, 0);
    chk(conv_pwr == 1'b0, "R10 pwr low", conv_pwr, 0);

    // R1 directed patterns
    run_burst(8'h04, 0, 4);
    run_burst(8'h06, 1, 5);
    run_burst(8'h81, 2, 4);
    run_burst(8'hFF, 0, 10);

    // R4: new mask with burst while a burst runs
    wr(mk(8'h01, 0, 1'b1, 0, 1'b0, 1'b1));
    wait_log(3);
    run_burst(8'h30, 0, 4);

    // random patterns
    for (int it = 0; it < 6; it++) begin
      int m;
      int d;
      int n;
      m = $urandom_range(1, 255);
      d = $urandom_range(0, 5);
      n = popc(m) + 2;
      if (n > 10) n = 10;
      run_burst(m, d, n);
    end

    // R6 read clears
    wait_cy(10);
    rd();
    chk(done == 1'b0, "R6 read clears done", done, 0);

    // R9 write during conversion
    wr(mk(8'h08, 0, 1'b0, 1, 1'b0, 1'b1));
    wait_cy(1);
    res_before = result;
    wr(mk(8'h10, 0, 1'b0, 1, 1'b0, 1'b1));
    chk(done == 1'b1, "R9 abort sets done", done, 1);
    chk(result == res_before, "R9 result kept", result, res_before);
    wait_cy(1);
    chk(nlog == 1 && log_ch[0] == 4, "R9 restart channel", log_ch[0], 4);
    wait_cy(10);
    chk(result_chan == 3'd4, "R5 result channel", result_chan, 4);
    chk(result == last_data, "R5 result data", result, last_data);

    // R7 single software conversion
    rd();
    wr(mk(8'h28, 0, 1'b0, 1, 1'b0, 1'b1));
    wait_cy(40);
    chk(nlog == 1, "R7 single conversion", nlog, 1);
    chk(log_ch[0] == 3, "R7 lowest channel", log_ch[0], 3);
    chk(done == 1'b1, "R6 done after completion", done, 1);
    chk(result_chan == 3'd3, "R5 tag", result_chan, 3);
    chk(result == last_data, "R5 data", result, last_data);
    rd();
    chk(done == 1'b0, "R6 cleared again", done, 0);

    // R8 rising edge on trig_in[1], level already high at write
    trig_in = 6'b000010;
    wr(mk(8'h02, 0, 1'b0, 3, 1'b0, 1'b1));
    wait_cy(20);
    chk(nlog == 0, "R8 level ignored", nlog, 0);
    trig_in[0] = 1'b1; wait_cy(4); trig_in[0] = 1'b0; wait_cy(4);
    chk(nlog == 0, "R8 unselected input ignored", nlog, 0);
    trig_in[1] = 1'b0; wait_cy(5);
    chk(nlog == 0, "R8 falling ignored in rising mode", nlog, 0);
    trig_in[1] = 1'b1; wait_cy(4);
    chk(nlog == 1 && log_ch[0] == 1, "R8 rising start", nlog, 1);
    wait_cy(15);

    // R8 falling edge on trig_in[5]
    trig_in = 6'b000000;
    wr(mk(8'h40, 0, 1'b0, 7, 1'b1, 1'b1));
    wait_cy(20);
    chk(nlog == 0, "R8 low level ignored", nlog, 0);
    trig_in[5] = 1'b1; wait_cy(6);
    chk(nlog == 0, "R8 rising ignored in falling mode", nlog, 0);
    trig_in[5] = 1'b0; wait_cy(4);
    chk(nlog == 1 && log_ch[0] == 6, "R8 falling start", log_ch[0], 6);
    wait_cy(15);

    // R10 global power-down overrides enable
    wr(mk(8'hFF, 0, 1'b1, 0, 1'b0, 1'b1));
    wait_log(2);
    @(negedge clk);
    sys_pd = 1'b1;
    @(posedge clk);
    #1 nlog = 0;
    @(negedge clk);
    chk(conv_pwr == 1'b0, "R10 pd drops pwr", conv_pwr, 0);
    wait_cy(40);
    chk(nlog == 0, "R10 no start in pd", nlog, 0);
    sys_pd = 1'b0;
    wait_cy(2);
    chk(conv_pwr == 1'b1, "R10 pwr back", conv_pwr, 1);

    summary();
    $finish;
  end
endmodule